// File: doc/BRIEF.md
# Scanline Interrupt Counter

This block raises a CPU interrupt once a programmed number of visible video lines has gone by. The CPU programs it through a small write port: a strobe, a 16-bit address and an 8-bit data byte. A once-per-line tick arrives from the video side. It carries the number of the line that just started, together with a flag that says whether rendering is on. The output is a level interrupt request. It stays high until the CPU acknowledges it.

Inside are an 8-bit reload latch, a signed down-counter, an enable flag and the pending-request flag. The CPU can load the counter directly, or load the latch and later copy it into the counter. On each tick for a visible line the block first checks the count. If the count is zero or negative and the block is enabled, the request is raised and the count holds for that line. Otherwise the count steps down, but only while rendering is on. A disabled counter therefore keeps running below zero, so enabling it late fires on the very next visible line.

Top module: `scanline_irq_counter`

## Requirements
- R1: After reset `irq_out` is low and the counter, latch and enable flag are all zero. A visible-line tick right after an enable write therefore raises the request at once.
- R2: A write whose address ANDed with 0xE001 equals 0xC000 loads the counter with the data byte, zero-extended (0 to 255).
- R3: A write decoding to 0xC001 loads the reload latch. A write decoding to 0xE000 copies the latch into the counter.
- R4: A write decoding to 0xE000 also clears the enable flag and drops `irq_out` from the next cycle on.
- R5: A write decoding to 0xE001 sets the enable flag and leaves the counter as it was.
- R6: Only bits 15..13 and bit 0 of the address are decoded. An address whose masked value is not one of the four above (for example 0x8000, 0xA001, 0x4100) changes nothing. Aliases such as 0xDFFE act like 0xC000.
- R7: A tick with `line_num` above 239 has no effect on the counter or on `irq_out`.
- R8: On a tick for lines 0 to 239, if the counter is zero or negative and the block is enabled, `irq_out` is high from the next cycle on and the counter keeps its value.
- R9: On any other tick for lines 0 to 239, the counter drops by one when `render_on` is high and holds when it is low.
- R10: The counter keeps counting below zero while the block is disabled. It stops at its most negative value (-512 at the default width) and never wraps to a positive value.
- R11: `irq_out` is sticky. Only reset or a write decoding to 0xE000 clears it; enable writes and further ticks leave it high.
- R12: In a cycle that carries a decoded write (R2 to R5), the tick in that same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write data |
| line_tick | input | 1 | One-cycle pulse at the start of each video line |
| line_num | input | 9 | Number of the line that the tick belongs to |
| render_on | input | 1 | Rendering-enabled flag |
| irq_out | output | 1 | Level interrupt request |

## Verification
Directed sequences load small counts, then tick with rendering on. These pin the exact line on which the request rises, which separates a counter that fires at zero from one that is off by one. The same counts are repeated with rendering off, with lines above 239, with an enable write sent while disabled after a long run below zero, and with ticks that coincide with writes. Each run shows whether the freeze, the hold and the ignore paths are kept apart from plain decrementing. Seeded random traffic mixes decoded, aliased and bystander addresses with ticks over the full 0 to 261 line range, and checks `irq_out` every cycle against a bench model.

// File: rtl/scl_pkg.sv
package scl_pkg;
  localparam int ADDR_W = 16;

  localparam logic [ADDR_W-1:0] DEC_MASK    = 16'hE001;
  localparam logic [ADDR_W-1:0] A_CNT_LOAD  = 16'hC000;
  localparam logic [ADDR_W-1:0] A_LAT_LOAD  = 16'hC001;
  localparam logic [ADDR_W-1:0] A_RELOAD    = 16'hE000;
  localparam logic [ADDR_W-1:0] A_ENABLE    = 16'hE001;

  typedef enum logic [2:0] {
    OP_NONE     = 3'd0,
    OP_CNT_LOAD = 3'd1,
    OP_LAT_LOAD = 3'd2,
    OP_RELOAD   = 3'd3,
    OP_ENABLE   = 3'd4
  } scl_op_e;

  function automatic scl_op_e decode_op(input logic strobe, input logic [ADDR_W-1:0] addr);
    logic [ADDR_W-1:0] masked;
    masked = addr & DEC_MASK;
    if (!strobe)                  return OP_NONE;
    else if (masked == A_CNT_LOAD) return OP_CNT_LOAD;
    else if (masked == A_LAT_LOAD) return OP_LAT_LOAD;
    else if (masked == A_RELOAD)   return OP_RELOAD;
    else if (masked == A_ENABLE)   return OP_ENABLE;
    else                           return OP_NONE;
  endfunction
endpackage

// File: rtl/scl_decode.sv
module scl_decode
  import scl_pkg::*;
(
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output scl_op_e           op
);
  always_comb op = decode_op(wr_en, wr_addr);
endmodule

// File: rtl/scl_counter.sv
module scl_counter
  import scl_pkg::*;
#(
  parameter int CW = 10,
  parameter int DW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  scl_op_e              op,
  input  logic [DW-1:0]        wr_data,
  input  logic                 tick_ok,
  input  logic                 render_on,
  input  logic                 en_q,
  output logic signed [CW-1:0] cnt_q,
  output logic                 fire_evt,
  output logic                 dec_evt
);
  localparam logic signed [CW-1:0] CNT_MIN = {1'b1, {(CW-1){1'b0}}};
  localparam logic [CW-1:0]        ONE     = {{(CW-1){1'b0}}, 1'b1};

  logic [DW-1:0] lat_q;
  logic          nonpos;

  function automatic logic signed [CW-1:0] widen(input logic [DW-1:0] v);
    return signed'({{(CW-DW){1'b0}}, v});
  endfunction

  function automatic logic signed [CW-1:0] step_down(input logic signed [CW-1:0] c);
    return (c == CNT_MIN) ? c : signed'(c - ONE);
  endfunction

  assign nonpos   = cnt_q[CW-1] || (cnt_q == '0);
  assign fire_evt = tick_ok && en_q && nonpos;
  assign dec_evt  = tick_ok && !fire_evt && render_on;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lat_q <= '0;
    end else begin
      if (op == OP_LAT_LOAD) lat_q <= wr_data;
      if (op == OP_CNT_LOAD)    cnt_q <= widen(wr_data);
      else if (op == OP_RELOAD) cnt_q <= widen(lat_q);
      else if (dec_evt)         cnt_q <= step_down(cnt_q);
    end
  end
endmodule

// File: rtl/scl_irq_ctl.sv
module scl_irq_ctl
  import scl_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  scl_op_e op,
  input  logic    fire_evt,
  output logic    en_q,
  output logic    irq_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (op == OP_RELOAD)      en_q <= 1'b0;
      else if (op == OP_ENABLE) en_q <= 1'b1;
      if (op == OP_RELOAD)      irq_q <= 1'b0;
      else if (fire_evt)        irq_q <= 1'b1;
    end
  end
endmodule

// File: rtl/scanline_irq_counter.sv
module scanline_irq_counter
  import scl_pkg::*;
#(
  parameter int DW        = 8,
  parameter int LW        = 9,
  parameter int CW        = 10,
  parameter int LAST_LINE = 239
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              line_tick,
  input  logic [LW-1:0]     line_num,
  input  logic              render_on,
  output logic              irq_out
);
  localparam logic [LW-1:0] LAST_L = LW'(LAST_LINE);

  scl_op_e               op;
  logic                  line_vis;
  logic                  tick_ok;
  logic signed [CW-1:0]  cnt_q;
  logic                  en_q;
  logic                  fire_evt;
  logic                  dec_evt;

  scl_decode u_dec (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .op      (op)
  );

  assign line_vis = line_num <= LAST_L;
  assign tick_ok  = line_tick && line_vis && (op == OP_NONE);

  scl_counter #(.CW(CW), .DW(DW)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .wr_data   (wr_data),
    .tick_ok   (tick_ok),
    .render_on (render_on),
    .en_q      (en_q),
    .cnt_q     (cnt_q),
    .fire_evt  (fire_evt),
    .dec_evt   (dec_evt)
  );

  scl_irq_ctl u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .fire_evt (fire_evt),
    .en_q     (en_q),
    .irq_q    (irq_out)
  );
endmodule

// File: rtl/scl_checker.sv
module scl_checker #(
  parameter int DW        = 8,
  parameter int LW        = 9,
  parameter int CW        = 10,
  parameter int LAST_LINE = 239
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [15:0]          wr_addr,
  input logic [DW-1:0]        wr_data,
  input logic                 line_tick,
  input logic [LW-1:0]        line_num,
  input logic signed [CW-1:0] cnt_q,
  input logic                 en_q,
  input logic                 irq_out,
  input logic                 fire_evt,
  input logic                 dec_evt
);
  localparam logic [CW-1:0] MOST_NEG = {1'b1, {(CW-1){1'b0}}};

  logic [15:0] m;
  logic any_wr, ld_w, clr_w, en_w;
  assign m      = wr_addr & 16'hE001;
  assign any_wr = wr_en && (m[15:14] == 2'b11);
  assign ld_w   = wr_en && (m == 16'hC000);
  assign clr_w  = wr_en && (m == 16'hE000);
  assign en_w   = wr_en && (m == 16'hE001);

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_w |=> (cnt_q == CW'($past(wr_data))));
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_w |=> (!irq_out && !en_q));
  p_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    en_w |=> (en_q && $stable(cnt_q)));
  p_offscreen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (line_tick && (line_num > LW'(LAST_LINE)) && !any_wr) |=> ($stable(cnt_q) && $stable(irq_out)));
  p_fire_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fire_evt |=> (irq_out && $stable(cnt_q)));
  p_dec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_evt && (cnt_q != MOST_NEG)) |=> (CW'(cnt_q) == CW'($past(cnt_q) - CW'(1))));
  p_floor_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_q == MOST_NEG) && !ld_w && !clr_w) |=> (cnt_q == MOST_NEG));
  p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && !clr_w) |=> irq_out);
  p_wrwins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (line_tick && any_wr && !ld_w && !clr_w) |=> $stable(cnt_q));
endmodule

bind scanline_irq_counter scl_checker #(
  .DW(DW), .LW(LW), .CW(CW), .LAST_LINE(LAST_LINE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .line_tick (line_tick),
  .line_num  (line_num),
  .cnt_q     (cnt_q),
  .en_q      (en_q),
  .irq_out   (irq_out),
  .fire_evt  (fire_evt),
  .dec_evt   (dec_evt)
);

// File: tb/tb_scanline_irq_counter.sv
`timescale 1ns/1ps
module tb_scanline_irq_counter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [15:0] wr_addr;
  logic [7:0]  wr_data;
  logic        line_tick;
  logic [8:0]  line_num;
  logic        render_on;
  logic        irq_out;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  int m_cnt, m_lat;
  bit m_en, m_irq;

  localparam int FLOOR = -512;

  always #5 clk = ~clk;

  scanline_irq_counter dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .line_tick(line_tick), .line_num(line_num), .render_on(render_on), .irq_out(irq_out)
  );

  function automatic int kind(bit we, logic [15:0] a);
    if (!we) return 0;
    case (a & 16'hE001)
      16'hC000: return 1;
      16'hC001: return 2;
      16'hE000: return 3;
      16'hE001: return 4;
      default:  return 0;
    endcase
  endfunction

  task automatic check(string tag, bit act, bit exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: irq_out=%0b expected %0b (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic step(string tag, bit we, logic [15:0] a, logic [7:0] d,
                      bit tk, int ln, bit rd);
    int k;
    bit ok, fire;
    int n_cnt, n_lat;
    bit n_en, n_irq;
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d;
    line_tick = tk; line_num = 9'(ln); render_on = rd;
    k = kind(we, a);
    ok = tk && (ln <= 239) && (k == 0);
    fire = ok && m_en && (m_cnt <= 0);
    n_cnt = m_cnt; n_lat = m_lat; n_en = m_en; n_irq = m_irq;
    if (k == 2) n_lat = d;
    if (k == 1) n_cnt = d;
    else if (k == 3) n_cnt = m_lat;
    else if (ok && !fire && rd) n_cnt = (m_cnt > FLOOR) ? m_cnt - 1 : m_cnt;
    if (k == 3) begin n_en = 0; n_irq = 0; end
    else begin
      if (k == 4) n_en = 1;
      if (fire) n_irq = 1;
    end
    @(posedge clk);
    m_cnt = n_cnt; m_lat = n_lat; m_en = n_en; m_irq = n_irq;
    #1;
    check(tag, irq_out, m_irq);
  endtask

  task automatic wr(string tag, logic [15:0] a, logic [7:0] d);
    step(tag, 1'b1, a, d, 1'b0, 0, 1'b0);
  endtask

  task automatic ticks(string tag, int n, int ln, bit rd);
    for (int i = 0; i < n; i++) step(tag, 1'b0, 16'h0, 8'h0, 1'b1, ln, rd);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        n_tests++; n_fail++;
        $display("FAIL watchdog: cycles=%0d expected below 200000", cycles);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    int r;
    bit we;
    logic [15:0] a;
    void'($urandom(32'd4242));
    rst_n = 1'b0; wr_en = 0; wr_addr = 0; wr_data = 0;
    line_tick = 0; line_num = 0; render_on = 0;
    m_cnt = 0; m_lat = 0; m_en = 0; m_irq = 0;
    repeat (3) @(posedge clk);
    #1 check("R1 reset", irq_out, 1'b0);
    @(negedge clk) rst_n = 1'b1;

    // R1: counter is zero after reset, so enable + tick fires at once
    wr("R1", 16'hE001, 8'h00);
    ticks("R1", 1, 10, 1'b1);
    check("R1 literal", irq_out, 1'b1);
    // R11: sticky through enable writes and further ticks
    wr("R11", 16'hE001, 8'h00);
    ticks("R11", 3, 20, 1'b1);
    check("R11 literal", irq_out, 1'b1);
    // R4: acknowledge clears
    wr("R4", 16'hE000, 8'h00);
    check("R4 literal", irq_out, 1'b0);
    // R3: latch then reload; count 5 fires on 6th tick
    wr("R3", 16'hC001, 8'd5);
    wr("R3", 16'hE000, 8'h00);
    wr("R3", 16'hE001, 8'h00);
    ticks("R3", 5, 30, 1'b1);
    check("R3 literal before", irq_out, 1'b0);
    ticks("R8", 1, 31, 1'b1);
    check("R8 literal", irq_out, 1'b1);
    // R9: render off holds
    wr("R9", 16'hE000, 8'h00);
    wr("R9", 16'hC000, 8'd2);
    wr("R5", 16'hE001, 8'h00);
    ticks("R9", 10, 40, 1'b0);
    ticks("R9", 2, 50, 1'b1);
    check("R9 literal", irq_out, 1'b0);
    ticks("R9", 1, 52, 1'b1);
    check("R9 literal fire", irq_out, 1'b1);
    // R7: off-screen lines ignored
    wr("R7", 16'hE000, 8'h00);
    wr("R7", 16'hC000, 8'd1);
    wr("R7", 16'hE001, 8'h00);
    ticks("R7", 1, 240, 1'b1);
    ticks("R7", 1, 261, 1'b1);
    ticks("R7", 1, 0, 1'b1);
    check("R7 literal", irq_out, 1'b0);
    ticks("R7", 1, 239, 1'b1);
    check("R7 literal fire", irq_out, 1'b1);
    // R10: negative while disabled, fires right after enable
    wr("R10", 16'hE000, 8'h00);
    wr("R10", 16'hC000, 8'd0);
    ticks("R10", 20, 100, 1'b1);
    wr("R10", 16'hE001, 8'h00);
    ticks("R10", 1, 101, 1'b1);
    check("R10 literal", irq_out, 1'b1);
    // R10: long run saturates instead of wrapping positive
    wr("R10", 16'hE000, 8'h00);
    wr("R10", 16'hC000, 8'd0);
    ticks("R10 floor", 700, 5, 1'b1);
    wr("R10", 16'hE001, 8'h00);
    ticks("R10 floor", 1, 6, 1'b1);
    check("R10 floor literal", irq_out, 1'b1);
    // R6: bystander writes ignored, alias decodes
    wr("R6", 16'hE000, 8'h00);
    wr("R6", 16'hC000, 8'd3);
    wr("R6", 16'hE001, 8'h00);
    wr("R6", 16'h8000, 8'h00);
    wr("R6", 16'hA001, 8'h00);
    wr("R6", 16'h4100, 8'h00);
    ticks("R6", 3, 60, 1'b1);
    check("R6 literal", irq_out, 1'b0);
    ticks("R6", 1, 61, 1'b1);
    check("R6 literal fire", irq_out, 1'b1);
    wr("R6", 16'hE000, 8'h00);
    wr("R6", 16'hC000, 8'd5);
    wr("R6", 16'hDFFE, 8'd0);
    wr("R6", 16'hE001, 8'h00);
    ticks("R6", 1, 62, 1'b1);
    check("R6 alias literal", irq_out, 1'b1);
    // R12: tick coinciding with a write is dropped
    wr("R12", 16'hE000, 8'h00);
    wr("R12", 16'hC000, 8'd0);
    wr("R12", 16'hE001, 8'h00);
    step("R12", 1'b1, 16'hC001, 8'd9, 1'b1, 70, 1'b1);
    check("R12 literal", irq_out, 1'b0);
    ticks("R12", 1, 71, 1'b1);
    check("R12 literal fire", irq_out, 1'b1);
    // R2: full-range direct load of 255
    wr("R2", 16'hE000, 8'h00);
    wr("R2", 16'hC000, 8'd255);
    wr("R2", 16'hE001, 8'h00);
    ticks("R2", 255, 80, 1'b1);
    check("R2 literal", irq_out, 1'b0);
    ticks("R2", 1, 81, 1'b1);
    check("R2 literal fire", irq_out, 1'b1);

    // Random traffic against the model (R8/R9 main function)
    for (int i = 0; i < 4000; i++) begin
      r = $urandom_range(0, 99);
      we = (r < 12);
      case ($urandom_range(0, 5))
        0: a = 16'hC000;
        1: a = 16'hC001;
        2: a = 16'hE000;
        3: a = 16'hE001;
        4: a = 16'($urandom_range(0, 16'hFFFF));
        default: a = 16'h8001;
      endcase
      if (r < 3 && a == 16'hC000) a = 16'hC000;
      step("R9 random", we, a, 8'($urandom_range(0, 12)),
           ($urandom_range(0, 3) != 0), $urandom_range(0, 261),
           ($urandom_range(0, 4) != 0));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule